// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks a long loop of `n` elements into pieces that a vector unit can process, each no longer than the maximum vector length (64 by default). A single start pulse loads the total element count. The block then offers one strip descriptor at a time to the downstream vector unit. Each descriptor carries the length to use for that strip and the index of its first element.

The short remainder piece, `n` modulo the maximum length, is issued first at index 0. Every following strip has the full maximum length and begins where the previous one ended. If `n` is an exact multiple of the maximum length, the remainder strip has length zero. It is still issued and is marked empty, so a run always has floor(n / max) + 1 strips.

Each descriptor stays on the outputs until the consumer accepts it. The final strip is flagged, and the block goes idle after that strip is taken.

Top module: `strip_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `strip_valid_o` is low.
- R2: A start pulse seen while idle makes `strip_valid_o` high on the next cycle. That first strip has length `total_i` mod 64 and start index 0.
- R3: Every strip after the first has length exactly 64.
- R4: One run issues exactly floor(`total_i` / 64) + 1 strips.
- R5: The start index of each later strip equals the previous strip's index plus the previous strip's length.
- R6: `strip_empty_o` is high exactly when the offered strip has length 0. This happens only for the first strip, and only when `total_i` is a multiple of 64.
- R7: A strip is taken only in a cycle where `strip_valid_o` and `strip_ready_i` are both high. While it waits, its length, index and last flag do not change.
- R8: `strip_last_o` is high only on the final strip of a run. The cycle after that strip is taken, `strip_valid_o` is low.
- R9: A start pulse that arrives while a run is being issued has no effect. The current run goes on unchanged, and no further strips follow it.
- R10: A count of zero yields one strip, of length 0, marked both empty and last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a run; used only while idle |
| total_i | input | CNT_W (16) | Total element count, sampled with start_i |
| strip_ready_i | input | 1 | Downstream accepts the offered strip |
| strip_valid_o | output | 1 | A strip descriptor is offered |
| strip_len_o | output | LEN_W (7) | Vector length of the offered strip |
| strip_base_o | output | CNT_W (16) | Index of the strip's first element |
| strip_last_o | output | 1 | Offered strip is the final one of the run |
| strip_empty_o | output | 1 | Offered strip has length zero |

## Verification
The bench uses a set of element counts to separate the remainder path from the full-strip path. A count of zero checks the lone empty strip. Counts of 64 and 128 check the empty remainder followed by full strips. Counts of 1 and 63 give a single short strip. Counts of 65, 200 and 300 give a partial strip followed by several full ones, and these show whether indices are advanced by the previous strip's actual length.

The consumer's ready signal is driven in three ways: always high, alternating, and pseudo-random. Comparing these separates correct back-to-back issue from correct stall behaviour. One run also receives a second start pulse partway through, which shows whether a busy block reloads.

// File: rtl/strip_pkg.sv
// Package strip_pkg: shared types for the strip-mining sequencer.
package strip_pkg;
    // Sequencer state: idle, or offering strips of a run.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/strip_plan.sv
// strip_plan: splits a total element count into the remainder length
// (the first strip) and the number of full-length strips after it.
// Assumes MAX_VLEN is a power of two, so both values come from bit slices.
// Purely combinational.
module strip_plan #(
    parameter int MAX_VLEN = 64,
    parameter int CNT_W    = 16,
    parameter int LOG_W    = $clog2(MAX_VLEN),
    parameter int LEN_W    = LOG_W + 1,
    parameter int QUO_W    = CNT_W - LOG_W
) (
    input  logic [CNT_W-1:0] total_i,
    output logic [LEN_W-1:0] first_len_o,
    output logic [QUO_W-1:0] full_cnt_o
);
    generate
        if (LOG_W == 0) begin : g_unit
            // Maximum length of one: there is never a remainder.
            always_comb begin
                first_len_o = '0;
                full_cnt_o  = total_i;
            end
        end else begin : g_slice
            // Low bits give the remainder, high bits give the quotient.
            always_comb begin
                first_len_o = LEN_W'(total_i[LOG_W-1:0]);
                full_cnt_o  = total_i[CNT_W-1:LOG_W];
            end
        end
    endgenerate
endmodule

// File: rtl/strip_walk.sv
// strip_walk: holds the descriptor of the strip currently offered and
// steps through the run. A load starts a run with the remainder strip at
// index 0. Each take either ends the run (no full strips left) or moves
// to the next full-length strip. A load is honoured only when the caller
// raises load_i, which the top does only while idle.
module strip_walk
    import strip_pkg::*;
#(
    parameter int MAX_VLEN = 64,
    parameter int CNT_W    = 16,
    parameter int LOG_W    = $clog2(MAX_VLEN),
    parameter int LEN_W    = LOG_W + 1,
    parameter int QUO_W    = CNT_W - LOG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] first_len_i,
    input  logic [QUO_W-1:0] full_cnt_i,
    input  logic             take_i,
    output logic             active_o,
    output logic [LEN_W-1:0] len_o,
    output logic [CNT_W-1:0] base_o,
    output logic             final_o
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_VLEN);

    seq_state_t       state_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] base_q;
    logic [QUO_W-1:0] left_q;

    // Advance the run state on load or on an accepted strip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            len_q   <= '0;
            base_q  <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            state_q <= SEQ_ISSUE;
            len_q   <= first_len_i;
            base_q  <= '0;
            left_q  <= full_cnt_i;
        end else if (take_i) begin
            if (left_q == '0) begin
                state_q <= SEQ_IDLE;
            end else begin
                base_q <= base_q + CNT_W'(len_q);
                len_q  <= FULL_LEN;
                left_q <= left_q - QUO_W'(1);
            end
        end
    end

    // Expose the current descriptor.
    always_comb begin
        active_o = (state_q == SEQ_ISSUE);
        len_o    = len_q;
        base_o   = base_q;
        final_o  = (left_q == '0);
    end

    // A run always opens at element index zero.
    assert_first_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> (base_o == '0));

    // After a non-final strip is taken, the next one is full length.
    assert_full_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && take_i && !final_o && !load_i) |=> (active_o && len_o == FULL_LEN));

    // The index moves forward by the length just consumed.
    assert_base_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && take_i && !final_o && !load_i) |=>
            (base_o == $past(base_o) + CNT_W'($past(len_o))));
endmodule

// File: rtl/strip_sequencer.sv
// strip_sequencer: top of the strip-mining vector length sequencer.
// Accepts a start pulse with an element count while idle, then offers
// strip descriptors (length, start index, last, empty) over a valid/ready
// handshake. The remainder strip comes first and full strips follow.
// Starts seen while busy are dropped. Assumes MAX_VLEN is a power of two.
module strip_sequencer #(
    parameter int MAX_VLEN = 64,
    parameter int CNT_W    = 16,
    parameter int LOG_W    = $clog2(MAX_VLEN),
    parameter int LEN_W    = LOG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             strip_ready_i,
    output logic             strip_valid_o,
    output logic [LEN_W-1:0] strip_len_o,
    output logic [CNT_W-1:0] strip_base_o,
    output logic             strip_last_o,
    output logic             strip_empty_o
);
    localparam int QUO_W = CNT_W - LOG_W;

    logic [LEN_W-1:0] first_len;
    logic [QUO_W-1:0] full_cnt;
    logic             active;
    logic             final_strip;
    logic             load;
    logic             take;

    strip_plan #(
        .MAX_VLEN(MAX_VLEN), .CNT_W(CNT_W), .LOG_W(LOG_W),
        .LEN_W(LEN_W), .QUO_W(QUO_W)
    ) u_plan (
        .total_i    (total_i),
        .first_len_o(first_len),
        .full_cnt_o (full_cnt)
    );

    // Start is honoured only while idle; a handshake consumes a strip.
    always_comb begin
        load = start_i && !active;
        take = active && strip_ready_i;
    end

    strip_walk #(
        .MAX_VLEN(MAX_VLEN), .CNT_W(CNT_W), .LOG_W(LOG_W),
        .LEN_W(LEN_W), .QUO_W(QUO_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .first_len_i(first_len),
        .full_cnt_i (full_cnt),
        .take_i     (take),
        .active_o   (active),
        .len_o      (strip_len_o),
        .base_o     (strip_base_o),
        .final_o    (final_strip)
    );

    // Drive the handshake flags from the walker state.
    always_comb begin
        strip_valid_o = active;
        strip_last_o  = active && final_strip;
        strip_empty_o = active && (strip_len_o == '0);
    end

    // Reset leaves nothing offered.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !strip_valid_o);

    // A waiting strip keeps its descriptor.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && !strip_ready_i) |=>
            (strip_valid_o && $stable(strip_len_o) && $stable(strip_base_o)
             && $stable(strip_last_o)));

    // After the last strip is taken the block is idle.
    assert_last_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && strip_ready_i && strip_last_o) |=> !strip_valid_o);

    // A start while busy and stalled changes nothing.
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && !strip_ready_i && start_i) |=>
            ($stable(strip_base_o) && $stable(strip_len_o)));

    // Only a zero-length strip is flagged empty, and never after the first.
    assert_empty_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && strip_ready_i && !strip_last_o) |=> !strip_empty_o);
endmodule

// File: tb/tb_strip_sequencer.sv
// Scoreboard bench: the driver queues expected strips, the monitor pops
// and compares them on every handshake.
module tb_strip_sequencer;
    localparam int CNT_W = 16;
    localparam int LEN_W = 7;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] base;
        logic             last;
        logic             empty;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] total_i = '0;
    logic             strip_ready_i = 1'b0;
    logic             strip_valid_o;
    logic [LEN_W-1:0] strip_len_o;
    logic [CNT_W-1:0] strip_base_o;
    logic             strip_last_o;
    logic             strip_empty_o;

    int    tests = 0;
    int    fails = 0;
    int    got_cnt = 0;
    int    rdy_mode = 0;
    bit    done = 1'b0;
    exp_t  sbq[$];
    logic [15:0] lfsr = 16'hACE1;
    bit    stalled = 1'b0;
    exp_t  held;

    strip_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_i(total_i),
        .strip_ready_i(strip_ready_i), .strip_valid_o(strip_valid_o),
        .strip_len_o(strip_len_o), .strip_base_o(strip_base_o),
        .strip_last_o(strip_last_o), .strip_empty_o(strip_empty_o)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Consumer ready pattern, changed 2 ns after each rising edge.
    initial forever begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       strip_ready_i = 1'b1;
            1:       strip_ready_i = lfsr[0];
            default: strip_ready_i = ~strip_ready_i;
        endcase
    end

    // Monitor: compare every accepted strip and every stalled hold.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (stalled) begin
                tests++;
                if (!strip_valid_o || strip_len_o != held.len ||
                    strip_base_o != held.base || strip_last_o != held.last) begin
                    fails++;
                    $display("FAIL R7 held strip changed: got v=%0b len=%0d base=%0d, exp len=%0d base=%0d",
                             strip_valid_o, strip_len_o, strip_base_o, held.len, held.base);
                end
            end
            stalled = strip_valid_o && !strip_ready_i;
            held = '{strip_len_o, strip_base_o, strip_last_o, strip_empty_o};
            if (strip_valid_o && strip_ready_i) begin
                tests++;
                got_cnt++;
                if (sbq.size() == 0) begin
                    fails++;
                    $display("FAIL R9 unexpected strip: got len=%0d base=%0d, exp none",
                             strip_len_o, strip_base_o);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (strip_len_o != e.len) begin
                        fails++;
                        if (e.base == 0)
                            $display("FAIL R2 first length: got %0d exp %0d", strip_len_o, e.len);
                        else
                            $display("FAIL R3 full length: got %0d exp %0d", strip_len_o, e.len);
                    end
                    if (strip_base_o != e.base) begin
                        fails++;
                        $display("FAIL R5 start index: got %0d exp %0d", strip_base_o, e.base);
                    end
                    if (strip_last_o != e.last) begin
                        fails++;
                        $display("FAIL R8 last flag: got %0b exp %0b", strip_last_o, e.last);
                    end
                    if (strip_empty_o != e.empty) begin
                        fails++;
                        $display("FAIL R6 empty flag: got %0b exp %0b", strip_empty_o, e.empty);
                    end
                end
            end
        end
    end

    // Driver: queue the expected strips, pulse start, wait for the run.
    // A non-negative extra_n pulses a second start mid-run (R9).
    task automatic run_seq(input int n, input int mode, input int extra_n);
        int rem = n % 64;
        int quo = n / 64;
        int base = rem;
        int wait_cyc = 0;
        rdy_mode = mode;
        got_cnt = 0;
        sbq.push_back('{LEN_W'(rem), CNT_W'(0), (quo == 0), (rem == 0)});
        for (int k = 1; k <= quo; k++) begin
            sbq.push_back('{LEN_W'(64), CNT_W'(base), (k == quo), 1'b0});
            base += 64;
        end
        @(posedge clk); #2;
        total_i = CNT_W'(n);
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        if (extra_n >= 0) begin
            repeat (2) @(posedge clk);
            #2;
            total_i = CNT_W'(extra_n);
            start_i = 1'b1;
            @(posedge clk); #2;
            start_i = 1'b0;
        end
        while (sbq.size() != 0 && wait_cyc < 2000) begin
            @(posedge clk);
            wait_cyc++;
        end
        repeat (3) begin
            @(negedge clk);
            tests++;
            if (strip_valid_o) begin
                fails++;
                $display("FAIL R8 not idle after last (n=%0d): got valid=1 exp 0", n);
            end
        end
        tests++;
        if (got_cnt != quo + 1) begin
            fails++;
            $display("FAIL R4 strip count for n=%0d: got %0d exp %0d", n, got_cnt, quo + 1);
        end
        sbq.delete();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired: got running exp finished");
        finish_run();
    end

    // Main sequence.
    initial begin
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            tests++;
            if (strip_valid_o !== 1'b0) begin
                fails++;
                $display("FAIL R1 valid in reset: got %b exp 0", strip_valid_o);
            end
        end
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (strip_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid after reset: got %b exp 0", strip_valid_o);
        end
        run_seq(0, 0, -1);    // R10: single empty last strip
        run_seq(64, 0, -1);   // R6: empty remainder then one full strip
        run_seq(1, 1, -1);    // R2: single short strip
        run_seq(63, 2, -1);   // R2
        run_seq(65, 0, -1);   // R3, R5
        run_seq(200, 1, -1);  // R3, R5, R7 under random stalls
        run_seq(128, 0, -1);  // R6, R4 back to back
        run_seq(300, 2, 5);   // R9: start mid-run is ignored
        run_seq(130, 1, -1);  // R4
        finish_run();
    end
endmodule